// File: doc/BRIEF.md
# Compressed Block Placement Controller

This controller decides where a compressed 64-byte block goes in a set-associative cache whose tag entries each describe one 64-byte data entry shared by blocks of a single super-block. A request carries the set index, the super-block tag, the 2-bit block id inside the super-block, the compressed size as a count of 16-byte sub-blocks (1, 2 or 4) and the new coherence state (any nonzero value is valid; zero means invalid). The controller updates its tag entries and answers with the chosen way, the sub-block offset inside the data entry, and any blocks it had to evict. The compression engine and the movement of data are handled elsewhere.

Placement is tried in a fixed order. First, a block that is already resident is updated where it sits when possible. Next, the block joins a resident entry of the same super-block and the same compression factor that has room. Next, an empty way is used. Last, a victim is evicted. Each tag entry keeps a 2-bit re-reference value, and the victim is chosen by that value. Eviction always frees a whole entry, and only that entry.

Top module: `cblk_alloc`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` is 0.
- R2: A size-1 block (quarter size) joins a valid entry with the same tag and quarter format when the position given by its block id is free. Its `res_off` always equals its block id.
- R3: A size-2 block (half size) joins a valid entry with the same tag and half format that holds exactly one valid block, and takes the free half. `res_off` is 0 for the lower half and 2 for the upper half. The two block ids need not be adjacent.
- R4: A size-4 block never shares an entry and has `res_off` 0. A block never joins an entry of a different format or of a different tag.
- R5: When a resident block is the only valid block in its entry, a request for it keeps the same way, rewrites the format and state for the new size, and reports `res_inplace`=1 with no eviction.
- R6: When a resident block shares its entry and its size changes, its old copy is invalidated (`res_moved`=1). It is then placed by the normal order, and the other blocks of that entry stay valid.
- R7: When a resident block shares its entry and its size is unchanged, it keeps its way and offset, only its state is updated, and `res_inplace`=1.
- R8: When no entry can be joined, the lowest-numbered empty way of the set is used before any eviction. Sets are independent.
- R9: When the set has no empty way, the victim is the lowest-numbered way whose re-reference value is 3. If no way has 3, every value in the set is incremented and the search repeats. A new allocation sets the value to 2, and a join or in-place update sets it to 0. `res_evict`=1, `res_evict_tag` gives the victim's tag and `res_evict_mask` bit i is set for each resident block id i. Other ways holding the same super-block stay valid.
- R10: `done` is a one-cycle pulse in the cycle after the tag update. `req_ready` is 1 only while the controller is idle, and a request is taken when `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Super-block tag |
| req_bid | input | 2 | Block id within the super-block |
| req_subs | input | 3 | Compressed size in 16-byte sub-blocks (1, 2, 4) |
| req_state | input | ST_W | New coherence state (nonzero) |
| done | output | 1 | Result valid pulse |
| res_way | output | WAY_W | Way chosen for the block |
| res_off | output | 2 | Sub-block offset of the block in the data entry |
| res_inplace | output | 1 | Block updated where it was resident |
| res_moved | output | 1 | Old copy of the block was invalidated |
| res_evict | output | 1 | A victim entry was evicted |
| res_evict_tag | output | TAG_W | Tag of the evicted entry |
| res_evict_mask | output | 4 | Block ids that were evicted |

## Verification
The bench builds the controller with four ways, two sets and a 6-bit tag. With only four ways, a set fills within a few requests, so victim selection, aging rounds that raise every value, and victims that are found at once without aging all occur in a short directed sequence. The expected results of that sequence follow from the requirements alone. The two sets make it possible to show that a tag resident in one set has no effect on placement in the other. The sequence covers halves with non-adjacent ids that share an entry, growth in place, relocation after invalidation, and the survival of sibling entries when a victim of the same super-block is evicted.

// File: rtl/cblk_alloc.sv
module cblk_alloc #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  parameter int ST_W  = 3,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [1:0]       req_bid,
  input  logic [2:0]       req_subs,
  input  logic [ST_W-1:0]  req_state,
  output logic             done,
  output logic [WAY_W-1:0] res_way,
  output logic [1:0]       res_off,
  output logic             res_inplace,
  output logic             res_moved,
  output logic             res_evict,
  output logic [TAG_W-1:0] res_evict_tag,
  output logic [3:0]       res_evict_mask
);

  localparam logic [1:0] F_FULL = 2'd1;
  localparam logic [1:0] F_HALF = 2'd2;
  localparam logic [1:0] F_QTR  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FIT, S_EVICT, S_WRITE} st_e;
  st_e state;

  logic [TAG_W-1:0] sb_q  [SETS][WAYS];
  logic [1:0]       fmt_q [SETS][WAYS];
  logic [1:0]       rr_q  [SETS][WAYS];
  logic [1:0]       bid_q [SETS][WAYS][4];
  logic [ST_W-1:0]  st_q  [SETS][WAYS][4];

  logic [SET_W-1:0] q_set;
  logic [TAG_W-1:0] q_tag;
  logic [1:0]       q_bid;
  logic [2:0]       q_subs;
  logic [ST_W-1:0]  q_st;
  logic [1:0]       q_fmt;
  logic [1:0]       new_slot;

  logic [WAY_W-1:0] t_way;
  logic [1:0]       t_slot;
  logic             t_wipe, t_new;

  assign q_fmt    = (q_subs == 3'd1) ? F_QTR : (q_subs == 3'd2) ? F_HALF : F_FULL;
  assign new_slot = (q_fmt == F_QTR) ? q_bid : 2'd0;
  assign req_ready = (state == S_IDLE);

  logic [2:0]       cnt [WAYS];
  logic             hit, join_ok, free_ok, vict_ok;
  logic [WAY_W-1:0] hit_way, join_way, free_way, vict_way;
  logic [1:0]       hit_slot, join_slot;
  logic [3:0]       vict_mask;

  always_comb begin
    hit = 1'b0; hit_way = '0; hit_slot = '0;
    join_ok = 1'b0; join_way = '0; join_slot = '0;
    free_ok = 1'b0; free_way = '0;
    vict_ok = 1'b0; vict_way = '0;
    vict_mask = '0;
    for (int w = 0; w < WAYS; w++) begin
      cnt[w] = '0;
      for (int s = 0; s < 4; s++)
        if (st_q[q_set][w][s] != '0) cnt[w] = cnt[w] + 3'd1;
    end
    for (int w = 0; w < WAYS; w++) begin
      for (int s = 0; s < 4; s++)
        if (!hit && sb_q[q_set][w] == q_tag && st_q[q_set][w][s] != '0 &&
            bid_q[q_set][w][s] == q_bid) begin
          hit = 1'b1; hit_way = WAY_W'(w); hit_slot = 2'(s);
        end
      if (!join_ok && cnt[w] != '0 && sb_q[q_set][w] == q_tag && fmt_q[q_set][w] == q_fmt) begin
        if (q_fmt == F_QTR && st_q[q_set][w][q_bid] == '0) begin
          join_ok = 1'b1; join_way = WAY_W'(w); join_slot = q_bid;
        end else if (q_fmt == F_HALF && cnt[w] == 3'd1) begin
          join_ok = 1'b1; join_way = WAY_W'(w);
          join_slot = (st_q[q_set][w][0] == '0) ? 2'd0 : 2'd1;
        end
      end
      if (!free_ok && cnt[w] == '0) begin
        free_ok = 1'b1; free_way = WAY_W'(w);
      end
      if (!vict_ok && rr_q[q_set][w] == 2'd3) begin
        vict_ok = 1'b1; vict_way = WAY_W'(w);
      end
    end
    for (int s = 0; s < 4; s++)
      if (st_q[q_set][vict_way][s] != '0) vict_mask[bid_q[q_set][vict_way][s]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0;
      q_set <= '0; q_tag <= '0; q_bid <= '0; q_subs <= '0; q_st <= '0;
      t_way <= '0; t_slot <= '0; t_wipe <= 1'b0; t_new <= 1'b0;
      res_way <= '0; res_off <= '0; res_inplace <= 1'b0; res_moved <= 1'b0;
      res_evict <= 1'b0; res_evict_tag <= '0; res_evict_mask <= '0;
      for (int i = 0; i < SETS; i++)
        for (int w = 0; w < WAYS; w++) begin
          sb_q[i][w] <= '0; fmt_q[i][w] <= '0; rr_q[i][w] <= '0;
          for (int s = 0; s < 4; s++) begin
            bid_q[i][w][s] <= '0; st_q[i][w][s] <= '0;
          end
        end
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          q_set <= req_set; q_tag <= req_tag; q_bid <= req_bid;
          q_subs <= req_subs; q_st <= req_state;
          t_new <= 1'b0; t_wipe <= 1'b0;
          res_inplace <= 1'b0; res_moved <= 1'b0; res_evict <= 1'b0;
          res_evict_tag <= '0; res_evict_mask <= '0;
          state <= S_LOOK;
        end
        S_LOOK: begin
          if (hit && cnt[hit_way] == 3'd1) begin
            t_way <= hit_way; t_wipe <= 1'b1; t_slot <= new_slot;
            res_inplace <= 1'b1; state <= S_WRITE;
          end else if (hit && fmt_q[q_set][hit_way] == q_fmt) begin
            t_way <= hit_way; t_slot <= hit_slot;
            res_inplace <= 1'b1; state <= S_WRITE;
          end else if (hit) begin
            st_q[q_set][hit_way][hit_slot] <= '0;
            res_moved <= 1'b1; state <= S_FIT;
          end else
            state <= S_FIT;
        end
        S_FIT: begin
          if (join_ok) begin
            t_way <= join_way; t_slot <= join_slot; state <= S_WRITE;
          end else if (free_ok) begin
            t_way <= free_way; t_slot <= new_slot; t_wipe <= 1'b1; t_new <= 1'b1;
            state <= S_WRITE;
          end else
            state <= S_EVICT;
        end
        S_EVICT: begin
          if (vict_ok) begin
            t_way <= vict_way; t_slot <= new_slot; t_wipe <= 1'b1; t_new <= 1'b1;
            res_evict <= 1'b1; res_evict_tag <= sb_q[q_set][vict_way];
            res_evict_mask <= vict_mask;
            state <= S_WRITE;
          end else
            for (int w = 0; w < WAYS; w++) rr_q[q_set][w] <= rr_q[q_set][w] + 2'd1;
        end
        S_WRITE: begin
          if (t_wipe) begin
            for (int s = 0; s < 4; s++) st_q[q_set][t_way][s] <= '0;
            fmt_q[q_set][t_way] <= q_fmt;
            sb_q[q_set][t_way]  <= q_tag;
          end
          st_q[q_set][t_way][t_slot]  <= q_st;
          bid_q[q_set][t_way][t_slot] <= q_bid;
          rr_q[q_set][t_way] <= t_new ? 2'd2 : 2'd0;
          res_way <= t_way;
          res_off <= (q_fmt == F_QTR) ? t_slot : (q_fmt == F_HALF) ? {t_slot[0], 1'b0} : 2'd0;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  qtr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_fmt == F_QTR) |-> res_off == q_bid);
  // R4
  full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_fmt == F_FULL) |-> res_off == 2'd0);
  // R5
  inplace_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_inplace) |-> (!res_evict && !res_moved));
  // R9
  evict_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_evict) |-> res_evict_mask != 4'd0);

endmodule

// File: tb/cblk_alloc_test.sv
module cblk_alloc_test;
  localparam int WAYS = 4, SETS = 2, TAG_W = 6, ST_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done;
  logic [0:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [1:0] req_bid = '0, res_way, res_off;
  logic [2:0] req_subs = '0;
  logic [ST_W-1:0] req_state = '0;
  logic res_inplace, res_moved, res_evict;
  logic [TAG_W-1:0] res_evict_tag;
  logic [3:0] res_evict_mask;

  int total = 0, bad = 0, cycles = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cblk_alloc #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .ST_W(ST_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_tag(req_tag), .req_bid(req_bid), .req_subs(req_subs),
    .req_state(req_state), .done(done), .res_way(res_way), .res_off(res_off),
    .res_inplace(res_inplace), .res_moved(res_moved), .res_evict(res_evict),
    .res_evict_tag(res_evict_tag), .res_evict_mask(res_evict_mask));

  // monitor: pops the scoreboard on each result
  always @(negedge clk) if (rst_n && done) begin
    logic [16:0] act, exp_v;
    string rq;
    act = {res_way, res_off, res_inplace, res_moved, res_evict,
           res_evict ? res_evict_tag : 6'd0, res_evict ? res_evict_mask : 4'd0};
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R10 unexpected done act=%h exp=none", act);
    end else begin
      exp_v = exp_q.pop_front();
      rq = tag_q.pop_front();
      if (act !== exp_v) begin
        bad++;
        $display("FAIL %s way/off/ip/mv/ev/tag/mask act=%h exp=%h", rq, act, exp_v);
      end
    end
  end

  task automatic op(input int st, input int tg, input int b, input int sz, input int cs,
                    input int ew, input int eo, input bit eip, input bit emv,
                    input bit eev, input int etag, input int emask, input string rq);
    while (!req_ready) @(negedge clk);
    req_set = 1'(st); req_tag = TAG_W'(tg); req_bid = 2'(b);
    req_subs = 3'(sz); req_state = ST_W'(cs); req_valid = 1'b1;
    exp_q.push_back({2'(ew), 2'(eo), eip, emv, eev, 6'(etag), 4'(emask)});
    tag_q.push_back(rq);
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (req_ready !== 1'b0) begin
      bad++; $display("FAIL R10 ready while busy act=%b exp=0", req_ready);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    total++;
    if (done !== 1'b0 || req_ready !== 1'b1) begin
      bad++; $display("FAIL R10 pulse act=%b%b exp=01", done, req_ready);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (req_ready !== 1'b1 || done !== 1'b0) begin
      bad++; $display("FAIL R1 reset act=%b%b exp=10", req_ready, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (req_ready !== 1'b1 || done !== 1'b0) begin
      bad++; $display("FAIL R1 idle act=%b%b exp=10", req_ready, done);
    end
    //  set tag bid sz st  way off ip mv ev etag mask
    op(0, 1, 0, 1, 1,  0, 0, 0, 0, 0, 0, 0, "R8");
    op(0, 1, 2, 1, 1,  0, 2, 0, 0, 0, 0, 0, "R2");
    op(0, 1, 3, 2, 1,  1, 0, 0, 0, 0, 0, 0, "R4");
    op(0, 1, 1, 2, 1,  1, 2, 0, 0, 0, 0, 0, "R3");
    op(0, 1, 1, 2, 2,  1, 2, 1, 0, 0, 0, 0, "R7");
    op(0, 1, 0, 2, 1,  2, 0, 0, 1, 0, 0, 0, "R6");
    op(0, 1, 2, 4, 3,  0, 0, 1, 0, 0, 0, 0, "R5");
    op(0, 2, 0, 4, 1,  3, 0, 0, 0, 0, 0, 0, "R8");
    op(0, 3, 1, 4, 1,  2, 0, 0, 0, 1, 1, 1, "R9");
    op(0, 4, 0, 4, 1,  3, 0, 0, 0, 1, 2, 1, "R9");
    op(0, 1, 3, 2, 2,  1, 0, 1, 0, 0, 0, 0, "R9");
    op(0, 5, 2, 2, 1,  2, 0, 0, 0, 1, 3, 2, "R9");
    op(0, 5, 0, 2, 1,  2, 2, 0, 0, 0, 0, 0, "R3");
    op(0, 6, 3, 1, 1,  3, 3, 0, 0, 1, 4, 1, "R9");
    op(1, 1, 0, 2, 1,  0, 0, 0, 0, 0, 0, 0, "R8");
    repeat (2) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++; $display("FAIL R10 missing results act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL R10 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule